// File: doc/BRIEF.md
# Multi-mode DMA Address Translator

This block sits on the inbound path from a pair of downstream ports. It turns each 64-bit bus address into a 64-bit system address, and it flags the address when no valid translation exists. The range that the bus address falls in selects one of five translation flavours:

- a 64-bit pass-through mode that carries its own attribute bits;
- a 32-bit window, relocated by a per-port base register;
- three table-driven windows, whose page sizes run from 256 KB to 16 GB.

A barrier attribute and a message-signalled-interrupt attribute are recovered from the address, or from the table entry, in the mode that carries them.

Software loads the two entry tables, the per-port base registers and the page-size code through one write port. The allocation of entries is left to software. A request is an address, a port number and a valid strobe. The result appears on the outputs exactly one clock later, with its own valid flag.

Top module: `dmx_xlate`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after a cycle in which `req_valid_i` was high. While `rsp_valid_o` is low, the address, barrier, MSI and fault outputs are all zero.
- R2: Bus address bit 63 set selects 64-bit direct mode, provided bits 60:54 are zero:
  - the output address is bits 53:0 zero-extended;
  - the barrier flag is bit 62;
  - the MSI flag is bit 61.
- R3: In 64-bit direct mode, any nonzero bit in 60:54 raises the fault flag.
- R4: Addresses 0x8000_0000 to 0xFFFF_FFFF form the 32-bit direct mode:
  - the output is bits 63:30 of the requesting port's base register, joined to bus bits 29:0;
  - the barrier flag is bus bit 30;
  - the MSI flag is zero;
  - no fault is raised.
- R5: Addresses 0x0 to 0x7FFF_FFFF form the 32-bit table mode:
  - the page is 2^(18+2*code) bytes, so a code of 0 gives 256 KB;
  - the entry index is bus bits 29:0 divided by the page size, read from the shared table;
  - the barrier flag is bus bit 30.
- R6: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF form the 40-bit table mode:
  - pages are 64 MB;
  - the index is bus bits 37:26, read from the second table;
  - the barrier flag is always zero.
- R7: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF form the 40-bit superpage mode:
  - pages are 16 GB;
  - the index is bus bits 38:34 plus 32 times the port number, read from the shared table;
  - the barrier flag is always zero.
- R8: A table entry has its valid flag in bit 63, its MSI flag in bit 62 and the target in bits 61:0:
  - a hit produces the target with its in-page bits cleared, OR'd with the in-page offset of the bus address;
  - a hit with bit 63 clear raises the fault flag, and then the address, barrier and MSI outputs are zero.
- R9: A table mode whose computed index is at or beyond the depth of its table raises the fault flag.
- R10: Addresses in none of the five ranges raise the fault flag. These are 0x1_0000_0000 to 0x3F_FFFF_FFFF, and bit 63 clear with any of bits 62:40 set.
- R11: A write with `wr_en_i` high stores `wr_data_i` into the target given by `wr_target_i`:
  - 0 selects shared-table entry `wr_idx_i`;
  - 1 selects second-table entry `wr_idx_i`;
  - 2 selects the base register of port `wr_idx_i`;
  - 3 selects the page-size code, taken from data bits 1:0.
  
  An index beyond the target's size is ignored. A lookup presented in the same cycle as a write sees the old contents; a lookup in the next cycle sees the new ones.
- R12: After reset:
  - all table entries are invalid;
  - both port base registers are zero;
  - the page-size code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup strobe |
| req_addr_i | input | 64 | Bus address to translate |
| req_port_i | input | 1 | Requesting port (0 or 1) |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_target_i | input | 2 | Write target: 0 shared table, 1 second table, 2 port base, 3 page code |
| wr_idx_i | input | 7 | Entry or port index for the write |
| wr_data_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the strobe |
| rsp_addr_o | output | 64 | Translated system address |
| rsp_barrier_o | output | 1 | Barrier attribute |
| rsp_msi_o | output | 1 | MSI attribute |
| rsp_fault_o | output | 1 | No valid translation |

## Verification
The assertions check properties of every cycle:
- the one-cycle response timing, and the quiet outputs between responses;
- the fault-implies-zero rule;
- the full 64-bit direct mapping, and its reserved-bit fault;
- the low bits and barrier flag of the 32-bit direct mode;
- the missing barrier in the 40-bit modes;
- the faults for unmapped ranges.

The table-driven results depend on the stored state, so only the bench's scenarios can show them. These cover:
- page-size changes and in-page offsets;
- the per-port split of the superpage region;
- out-of-depth indices;
- ignored writes;
- the old-data rule when a write and a lookup share a cycle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int AW            = 64;
  localparam int PG_BASE_SHIFT = 18;   // 256 KB at code 0
  localparam int L40_SHIFT     = 26;   // 64 MB
  localparam int SUPER_SHIFT   = 34;   // 16 GB
  localparam int SP_PER_PORT   = 1 << (39 - SUPER_SHIFT);
  localparam int ENT_VALID     = 63;
  localparam int ENT_MSI       = 62;

  localparam logic [1:0] WT_SHARED = 2'd0;
  localparam logic [1:0] WT_L40    = 2'd1;
  localparam logic [1:0] WT_DMAP   = 2'd2;
  localparam logic [1:0] WT_PCODE  = 2'd3;

  typedef enum logic [2:0] {
    MODE_NONE, MODE_D64, MODE_D32, MODE_M32, MODE_M40, MODE_M40S
  } xlt_mode_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          barrier;
    logic          msi;
    logic          fault;
  } xlt_rsp_t;
endpackage

// File: rtl/dmx_range_decode.sv
module dmx_range_decode
  import dmx_pkg::*;
#(
  parameter int SH_DEPTH  = 128,
  parameter int L40_DEPTH = 64,
  parameter int SH_IW     = 7,
  parameter int L40_IW    = 6,
  parameter int PW        = 1
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [PW-1:0]     port_i,
  input  logic [1:0]        pcode_i,
  output xlt_mode_e         mode_o,
  output logic [SH_IW-1:0]  sh_idx_o,
  output logic [L40_IW-1:0] l40_idx_o,
  output logic [AW-1:0]     page_mask_o,
  output logic              idx_oor_o,
  output logic              rsvd_bad_o
);
  logic [5:0]    shift;
  logic [AW-1:0] full_idx;

  always_comb begin
    shift       = 6'(PG_BASE_SHIFT) + {3'b0, pcode_i, 1'b0};
    mode_o      = MODE_NONE;
    full_idx    = '0;
    page_mask_o = '0;
    idx_oor_o   = 1'b0;
    rsvd_bad_o  = 1'b0;
    if (addr_i[63]) begin
      mode_o     = MODE_D64;
      rsvd_bad_o = |addr_i[60:54];
    end else if (addr_i[62:32] == '0 && addr_i[31]) begin
      mode_o = MODE_D32;
    end else if (addr_i[62:31] == '0) begin
      mode_o      = MODE_M32;
      page_mask_o = (64'd1 << shift) - 64'd1;
      full_idx    = {34'd0, addr_i[29:0]} >> shift;   // bit 30 is barrier
      idx_oor_o   = full_idx >= 64'(SH_DEPTH);
    end else if (addr_i[62:39] == '0 && addr_i[38]) begin
      mode_o      = MODE_M40;
      page_mask_o = (64'd1 << L40_SHIFT) - 64'd1;
      full_idx    = {52'd0, addr_i[37:26]};
      idx_oor_o   = full_idx >= 64'(L40_DEPTH);
    end else if (addr_i[62:40] == '0 && addr_i[39]) begin
      mode_o      = MODE_M40S;
      page_mask_o = (64'd1 << SUPER_SHIFT) - 64'd1;
      full_idx    = 64'(port_i) * 64'(SP_PER_PORT) + {59'd0, addr_i[38:34]};
      idx_oor_o   = full_idx >= 64'(SH_DEPTH);
    end
  end

  assign sh_idx_o  = full_idx[SH_IW-1:0];
  assign l40_idx_o = full_idx[L40_IW-1:0];
endmodule

// File: rtl/dmx_entry_table.sv
module dmx_entry_table #(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int DW    = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  // index range is guarded by the caller
  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/dmx_xlate.sv
module dmx_xlate
  import dmx_pkg::*;
#(
  parameter int NPORTS    = 2,
  parameter int SH_DEPTH  = 128,
  parameter int L40_DEPTH = 64,
  localparam int SH_IW    = $clog2(SH_DEPTH),
  localparam int L40_IW   = $clog2(L40_DEPTH),
  localparam int WIW      = (SH_IW > L40_IW) ? SH_IW : L40_IW,
  localparam int PW       = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [PW-1:0] req_port_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_target_i,
  input  logic [WIW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_barrier_o,
  output logic          rsp_msi_o,
  output logic          rsp_fault_o
);
  xlt_mode_e         mode;
  logic [SH_IW-1:0]  sh_idx;
  logic [L40_IW-1:0] l40_idx;
  logic [AW-1:0]     page_mask;
  logic              idx_oor, rsvd_bad;
  logic [1:0]        pcode_q;
  logic [AW-1:0]     dmap_q [NPORTS];
  logic [AW-1:0]     dmap_sel;
  logic [AW-1:0]     sh_rd, l40_rd, ent;
  logic              sh_we, l40_we;
  xlt_rsp_t          nxt, rsp_q;
  logic              vld_q;

  dmx_range_decode #(
    .SH_DEPTH(SH_DEPTH), .L40_DEPTH(L40_DEPTH),
    .SH_IW(SH_IW), .L40_IW(L40_IW), .PW(PW)
  ) u_dec (
    .addr_i(req_addr_i), .port_i(req_port_i), .pcode_i(pcode_q),
    .mode_o(mode), .sh_idx_o(sh_idx), .l40_idx_o(l40_idx),
    .page_mask_o(page_mask), .idx_oor_o(idx_oor), .rsvd_bad_o(rsvd_bad)
  );

  assign sh_we  = wr_en_i && wr_target_i == WT_SHARED && 32'(wr_idx_i) < SH_DEPTH;
  assign l40_we = wr_en_i && wr_target_i == WT_L40    && 32'(wr_idx_i) < L40_DEPTH;

  dmx_entry_table #(.DEPTH(SH_DEPTH), .IW(SH_IW), .DW(AW)) u_sh_tbl (
    .clk_i, .rst_ni, .we_i(sh_we), .widx_i(wr_idx_i[SH_IW-1:0]),
    .wdata_i(wr_data_i), .ridx_i(sh_idx), .rdata_o(sh_rd)
  );

  dmx_entry_table #(.DEPTH(L40_DEPTH), .IW(L40_IW), .DW(AW)) u_l40_tbl (
    .clk_i, .rst_ni, .we_i(l40_we), .widx_i(wr_idx_i[L40_IW-1:0]),
    .wdata_i(wr_data_i), .ridx_i(l40_idx), .rdata_o(l40_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcode_q <= '0;
      for (int p = 0; p < NPORTS; p++) dmap_q[p] <= '0;
    end else if (wr_en_i) begin
      if (wr_target_i == WT_PCODE) pcode_q <= wr_data_i[1:0];
      for (int p = 0; p < NPORTS; p++)
        if (wr_target_i == WT_DMAP && 32'(wr_idx_i) == p) dmap_q[p] <= wr_data_i;
    end
  end

  generate
    if (NPORTS > 1) begin : g_dmap_mux
      assign dmap_sel = (32'(req_port_i) < NPORTS) ? dmap_q[req_port_i] : '0;
    end else begin : g_dmap_one
      assign dmap_sel = dmap_q[0];
    end
  endgenerate

  assign ent = (mode == MODE_M40) ? l40_rd : sh_rd;

  always_comb begin
    nxt = '0;
    unique case (mode)
      MODE_D64: begin
        if (rsvd_bad) nxt.fault = 1'b1;
        else begin
          nxt.addr    = {10'd0, req_addr_i[53:0]};
          nxt.barrier = req_addr_i[62];
          nxt.msi     = req_addr_i[61];
        end
      end
      MODE_D32: begin
        nxt.addr    = {dmap_sel[63:30], req_addr_i[29:0]};
        nxt.barrier = req_addr_i[30];
      end
      MODE_M32, MODE_M40, MODE_M40S: begin
        if (idx_oor || !ent[ENT_VALID]) nxt.fault = 1'b1;
        else begin
          nxt.addr    = ({2'b00, ent[61:0]} & ~page_mask) | (req_addr_i & page_mask);
          nxt.msi     = ent[ENT_MSI];
          nxt.barrier = (mode == MODE_M32) ? req_addr_i[30] : 1'b0;
        end
      end
      default: nxt.fault = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= req_valid_i;
      rsp_q <= req_valid_i ? nxt : '0;
    end
  end

  assign rsp_valid_o   = vld_q;
  assign rsp_addr_o    = rsp_q.addr;
  assign rsp_barrier_o = rsp_q.barrier;
  assign rsp_msi_o     = rsp_q.msi;
  assign rsp_fault_o   = rsp_q.fault;
endmodule

// File: rtl/dmx_xlate_chk.sv
module dmx_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic [63:0] rsp_addr_o,
  input logic        rsp_barrier_o,
  input logic        rsp_msi_o,
  input logic        rsp_fault_o
);
  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_addr_o == '0 && !rsp_fault_o && !rsp_barrier_o && !rsp_msi_o));

  p_d64_map_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[63] && req_addr_i[60:54] == '0) |=>
      (!rsp_fault_o && rsp_addr_o == {10'd0, $past(req_addr_i[53:0])} &&
       rsp_barrier_o == $past(req_addr_i[62]) && rsp_msi_o == $past(req_addr_i[61])));

  p_d64_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[63] && req_addr_i[60:54] != '0) |=> rsp_fault_o);

  p_d32_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[63:32] == '0 && req_addr_i[31]) |=>
      (!rsp_fault_o && !rsp_msi_o && rsp_addr_o[29:0] == $past(req_addr_i[29:0]) &&
       rsp_barrier_o == $past(req_addr_i[30])));

  p_wide_nobar_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[63:40] == '0 && req_addr_i[39:38] != 2'b00) |=> !rsp_barrier_o);

  p_fault_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_addr_o == '0 && !rsp_barrier_o && !rsp_msi_o));

  p_gap_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ((!req_addr_i[63] && req_addr_i[62:40] != '0) ||
                     (req_addr_i[63:38] == '0 && req_addr_i[37:32] != '0))) |=> rsp_fault_o);
endmodule

bind dmx_xlate dmx_xlate_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o), .rsp_barrier_o(rsp_barrier_o),
  .rsp_msi_o(rsp_msi_o), .rsp_fault_o(rsp_fault_o)
);

// File: tb/dmx_xlate_test.sv
module dmx_xlate_test;
  localparam int SHD = 128;
  localparam int L4D = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        req_port_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_target_i = '0;
  logic [6:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        rsp_valid_o, rsp_barrier_o, rsp_msi_o, rsp_fault_o;
  logic [63:0] rsp_addr_o;

  int n_checks = 0;
  int n_errors = 0;

  logic [63:0] sh_m [SHD];
  logic [63:0] l4_m [L4D];
  logic [63:0] dm_m [2];
  int          pcode_m;

  typedef struct { logic [63:0] a; bit b; bit m; bit f; } exp_t;

  always #10 clk = ~clk;

  dmx_xlate uut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_addr_i, .req_port_i,
    .wr_en_i, .wr_target_i, .wr_idx_i, .wr_data_i,
    .rsp_valid_o, .rsp_addr_o, .rsp_barrier_o, .rsp_msi_o, .rsp_fault_o
  );

  function automatic exp_t model(input logic [63:0] a, input bit p);
    exp_t r;
    logic [63:0] e, pg, off, idx;
    r = '{a: '0, b: 0, m: 0, f: 0};
    if (a[63]) begin
      if (a[60:54] != 0) r.f = 1;
      else begin r.a = {10'd0, a[53:0]}; r.b = a[62]; r.m = a[61]; end
    end else if (a[62:32] == 0 && a[31]) begin
      r.a = {dm_m[p][63:30], a[29:0]}; r.b = a[30];
    end else if (a[62:40] == 0 && (a[62:31] == 0 || a[39:38] != 0)) begin
      if (a[62:31] == 0) begin
        pg = 64'd1 << (18 + 2 * pcode_m); off = {34'd0, a[29:0]};
        idx = off / pg; r.b = a[30];
      end else if (a[39] == 0) begin
        pg = 64'd1 << 26; off = {38'd0, a[25:0]}; idx = {52'd0, a[37:26]};
      end else begin
        pg = 64'd1 << 34; off = {30'd0, a[33:0]}; idx = 64'(p) * 32 + {59'd0, a[38:34]};
      end
      if (a[62:31] != 0 && a[39] == 0) e = (idx < L4D) ? l4_m[idx] : '0;
      else e = (idx < SHD) ? sh_m[idx] : '0;
      if (!e[63]) r.f = 1;
      else begin r.a = ({2'b0, e[61:0]} / pg) * pg + off % pg; r.m = e[62]; end
      if (r.f) r.b = 0;
    end else r.f = 1;
    return r;
  endfunction

  function automatic string tag_of(input logic [63:0] a);
    if (a[63]) return (a[60:54] != 0) ? "R3" : "R2";
    if (a[62:32] == 0 && a[31]) return "R4";
    if (a[62:31] == 0) return "R5";
    if (a[62:39] == 0 && a[38]) return "R6";
    if (a[62:40] == 0 && a[39]) return "R7";
    return "R10";
  endfunction

  task automatic check(input string req, input exp_t x);
    n_checks++;
    if (rsp_valid_o !== 1'b1 || rsp_addr_o !== x.a || rsp_barrier_o !== x.b ||
        rsp_msi_o !== x.m || rsp_fault_o !== x.f) begin
      n_errors++;
      $display("FAIL %s: got v=%0b a=%h b=%0b m=%0b f=%0b exp v=1 a=%h b=%0b m=%0b f=%0b",
               req, rsp_valid_o, rsp_addr_o, rsp_barrier_o, rsp_msi_o, rsp_fault_o,
               x.a, x.b, x.m, x.f);
    end
  endtask

  task automatic wr(input logic [1:0] t, input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_target_i = t; wr_idx_i = 7'(idx); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
    case (t)
      2'd0: if (idx < SHD) sh_m[idx] = d;
      2'd1: if (idx < L4D) l4_m[idx] = d;
      2'd2: if (idx < 2) dm_m[idx] = d;
      default: pcode_m = int'(d[1:0]);
    endcase
  endtask

  task automatic look(input logic [63:0] a, input bit p, input string req);
    exp_t x;
    @(negedge clk);
    x = model(a, p);
    req_valid_i = 1; req_addr_i = a; req_port_i = p;
    @(negedge clk);
    req_valid_i = 0;
    check(req, x);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] rnd_addr();
    logic [63:0] r = rnd64();
    case ($urandom % 6)
      0: return {1'b1, r[62:61], (($urandom % 4) == 0) ? r[60:54] : 7'd0, r[53:0]};
      1: return {32'd0, 1'b1, r[30:0]};
      2: return {33'd0, r[30], r[29:0] >> ($urandom % 8)};
      3: return {24'd0, 2'b01, 12'($urandom % 72), r[25:0]};
      4: return {24'd0, 1'b1, r[38:0]};
      default: return {1'b0, r[62:0]};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    exp_t x;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < SHD; i++) sh_m[i] = '0;
    for (int i = 0; i < L4D; i++) l4_m[i] = '0;
    dm_m[0] = '0; dm_m[1] = '0; pcode_m = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 / R1: quiet outputs after reset
    n_checks++;
    if (rsp_valid_o !== 0 || rsp_addr_o !== 0 || rsp_fault_o !== 0) begin
      n_errors++;
      $display("FAIL R12: got v=%0b a=%h f=%0b exp all zero", rsp_valid_o, rsp_addr_o, rsp_fault_o);
    end
    look(64'h0000_0000_0001_2345, 0, "R12 table invalid");
    look(64'h0000_0000_C123_4567, 1, "R12 base zero");
    // R4 per-port base
    wr(2'd2, 1, 64'h1234_5678_C000_0ABC);
    wr(2'd2, 0, 64'h0000_00FF_4000_0000);
    look(64'h0000_0000_C123_4567, 1, "R4 port1");
    look(64'h0000_0000_8123_4567, 0, "R4 port0");
    // R2 / R3
    look(64'hE000_0012_3456_789A, 0, "R2 flags");
    look(64'h8040_0000_0000_0001, 0, "R3 reserved");
    // R5 / R8 table 32-bit at 256 KB pages
    wr(2'd0, 5, 64'hC000_0123_4560_0000);
    look(64'h0000_0000_4015_1234, 0, "R5 hit barrier");
    look(64'h0000_0000_0015_1234, 1, "R8 msi entry");
    wr(2'd0, 6, 64'h4000_0000_0ABC_0000);
    look(64'h0000_0000_0018_0010, 0, "R8 invalid entry");
    // R5 page code 1 -> 1 MB, index 1 covers entry 1
    wr(2'd0, 1, 64'h8000_0007_0000_0000);
    wr(2'd3, 0, 64'd1);
    look(64'h0000_0000_001A_BCDE, 0, "R5 1MB page");
    wr(2'd3, 0, 64'd0);
    // R9 beyond shared depth
    look(64'h0000_0000_0200_0000, 0, "R9 m32 depth");
    // R6 40-bit table
    wr(2'd1, 3, 64'hC000_00AB_C000_0000);
    look(64'h0000_0040_0C12_3456, 0, "R6 hit");
    look(64'h0000_0041_0000_0000, 0, "R9 m40 depth");
    // R11 write beyond depth is ignored (would alias entry 3)
    wr(2'd1, 67, 64'h8000_0000_0000_0000);
    look(64'h0000_0040_0C00_0004, 0, "R11 ignored write");
    // R7 superpage split
    wr(2'd0, 36, 64'h8000_1230_0000_0000);
    look(64'h0000_0091_2345_6789, 1, "R7 port1 hit");
    look(64'h0000_0091_2345_6789, 0, "R7 port0 miss");
    // R10 gaps
    look(64'h0000_0001_0000_0000, 0, "R10 low gap");
    look(64'h0000_0100_0000_0000, 1, "R10 high gap");
    // R11 same-cycle write sees old, next cycle sees new
    @(negedge clk);
    x = model(64'h0000_0000_0020_0044, 0);
    wr_en_i = 1; wr_target_i = 2'd0; wr_idx_i = 7'd8; wr_data_i = 64'h8000_0000_3330_0000;
    req_valid_i = 1; req_addr_i = 64'h0000_0000_0020_0044; req_port_i = 0;
    @(negedge clk);
    wr_en_i = 0; req_valid_i = 0;
    check("R11 same cycle old", x);
    sh_m[8] = 64'h8000_0000_3330_0000;
    look(64'h0000_0000_0020_0044, 0, "R11 next cycle new");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 10;
      if (r < 3) begin
        logic [63:0] d = rnd64();
        d[63] = ($urandom % 3) != 0;
        if ($urandom % 2) wr(2'd0, $urandom % SHD, d);
        else wr(2'd1, $urandom % 128, d);
      end else if (r == 3) begin
        if ($urandom % 2) wr(2'd2, $urandom % 2, rnd64());
        else wr(2'd3, 0, 64'($urandom % 4));
      end else begin
        logic [63:0] a = rnd_addr();
        look(a, 1'($urandom % 2), tag_of(a));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule